// File: doc/BRIEF.md
# Tiered State-Enable Register File

This block keeps three tiers of 64-bit state-enable control registers for a core with machine, hypervisor and supervisor privilege levels. Each tier holds four registers. Every register's top bit (bit 63) is the tier-open bit. When that bit is clear in a higher tier, the register with the same index in the tier below cannot be reached. The block takes a CSR access request together with the hart's current privilege and virtualization state. In the same cycle it either returns masked read data or reports an illegal-instruction or virtual-instruction fault. A legal write is committed at the next clock edge.

Each lower tier is filtered by the tier above it. What software reads back from a lower register, and which of its bits a write may change, is the stored value ANDed with the higher register of the same index. The supervisor tier is also ANDed with the hypervisor tier while the hart runs virtualized. With a 32-bit data path, the machine and hypervisor tiers also answer at upper-half alias addresses that reach bits 63:32. The register storage is not touched by anything outside this block.

Top module: `stateen_csr_file`

## Requirements
- R1: After reset all twelve registers read as zero.
- R2: Decoded addresses (low two address bits = register index 0..3). Machine tier: 0x30C-0x30F, with upper halves at 0x31C-0x31F. Hypervisor tier: 0x60C-0x60F, with upper halves at 0x61C-0x61F. Supervisor tier: 0x10C-0x10F only. Upper-half aliases are decoded only when XLEN is 32. For any other address `rsp_hit_o` is 0, no fault is raised and read data is 0.
- R3: A write changes only the bits set in `WR_MASK` (default: bit 63 alone). All other bits keep their value.
- R4: When `ext_en_i` is 0, every decoded access raises the illegal-instruction fault.
- R5: Base privilege checks (`priv_i`: 0 = user, 1 = supervisor, 3 = machine). The machine tier needs machine mode. The hypervisor tier needs machine mode, or supervisor mode with `virt_i` clear. The supervisor tier needs supervisor or machine mode. A failed check raises the illegal-instruction fault. `virt_i` is ignored in machine mode.
- R6: An access to hypervisor register n, either half, raises the illegal-instruction fault when bit 63 of machine register n is 0.
- R7: An access to supervisor register n raises the illegal-instruction fault when bit 63 of machine register n is 0. Otherwise, when virtualized and bit 63 of hypervisor register n is 0, it raises the virtual-instruction fault. The two faults never occur together.
- R8: Read data is masked by tier. Hypervisor n reads as stored & machine n. Supervisor n reads as stored & machine n, further ANDed with hypervisor n when virtualized.
- R9: Writes are masked by tier. The write mask is `WR_MASK`, ANDed with machine n for the hypervisor tier. For the supervisor tier it is ANDed with machine n and, when virtualized, with hypervisor n. The new value is (old & ~mask) | (data & mask).
- R10: With XLEN 32, a low-half address reads and writes bits 31:0 and an upper-half alias reads and writes bits 63:32. A write through either address leaves the other half unchanged.
- R11: A faulting access returns zero read data and changes no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ext_en_i | input | 1 | The state-enable feature is implemented and enabled |
| priv_i | input | 2 | Current privilege: 0 user, 1 supervisor, 3 machine |
| virt_i | input | 1 | Hart is running virtualized |
| req_valid_i | input | 1 | A CSR access is presented this cycle |
| req_we_i | input | 1 | The access writes |
| req_addr_i | input | 12 | CSR address |
| req_wdata_i | input | XLEN | Write data |
| rsp_hit_o | output | 1 | The address belongs to this block |
| rsp_rdata_o | output | XLEN | Masked read data (pre-write value), zero on fault |
| rsp_illegal_o | output | 1 | Illegal-instruction fault |
| rsp_virtual_o | output | 1 | Virtual-instruction fault |

## Verification
A corrupted stored bit in a higher tier shows up in the same cycle on the next access to the tier below. It appears as a wrong fault type or as extra or missing read-back bits. A mis-committed write shows up on the first later read of that register or of any register it gates. The bench therefore follows each write with reads of the written register and of the tiers it masks, under both virtualization states. This catches a wrong mask or a half-write at the first read after the faulty edge.

// File: rtl/stateen_pkg.sv
package stateen_pkg;
  localparam int unsigned STATEEN_REGS = 4;
  localparam int unsigned STATEEN_W    = 64;
  localparam int unsigned HALF_W       = STATEEN_W / 2;
  localparam int unsigned IDX_W        = $clog2(STATEEN_REGS);
  localparam int unsigned OPEN_BIT     = STATEEN_W - 1;

  localparam logic [1:0] PRIV_U = 2'b00;
  localparam logic [1:0] PRIV_S = 2'b01;
  localparam logic [1:0] PRIV_M = 2'b11;

  typedef enum logic [1:0] {
    TIER_NONE = 2'd0,
    TIER_M    = 2'd1,
    TIER_H    = 2'd2,
    TIER_S    = 2'd3
  } tier_e;

  typedef struct packed {
    tier_e            tier;
    logic             upper;
    logic [IDX_W-1:0] idx;
  } sel_t;

  typedef logic [STATEEN_REGS-1:0][STATEEN_W-1:0] bank_t;
endpackage

// File: rtl/stateen_addr_decode.sv
module stateen_addr_decode
  import stateen_pkg::*;
#(
  parameter int unsigned XLEN = 32
) (
  input  logic [11:0] addr_i,
  output sel_t        sel_o
);
  localparam int unsigned GRP_W = 12 - IDX_W;
  localparam logic [GRP_W-1:0] GRP_M_LO = GRP_W'(12'h30C >> IDX_W);
  localparam logic [GRP_W-1:0] GRP_M_HI = GRP_W'(12'h31C >> IDX_W);
  localparam logic [GRP_W-1:0] GRP_H_LO = GRP_W'(12'h60C >> IDX_W);
  localparam logic [GRP_W-1:0] GRP_H_HI = GRP_W'(12'h61C >> IDX_W);
  localparam logic [GRP_W-1:0] GRP_S_LO = GRP_W'(12'h10C >> IDX_W);
  localparam bit HAS_UPPER = (XLEN == 32);

  logic [GRP_W-1:0] grp;
  assign grp = addr_i[11:IDX_W];

  always_comb begin
    sel_o.tier  = TIER_NONE;
    sel_o.upper = 1'b0;
    sel_o.idx   = addr_i[IDX_W-1:0];
    if (grp == GRP_M_LO) begin
      sel_o.tier = TIER_M;
    end else if (grp == GRP_H_LO) begin
      sel_o.tier = TIER_H;
    end else if (grp == GRP_S_LO) begin
      sel_o.tier = TIER_S;
    end else if (HAS_UPPER && grp == GRP_M_HI) begin
      sel_o.tier  = TIER_M;
      sel_o.upper = 1'b1;
    end else if (HAS_UPPER && grp == GRP_H_HI) begin
      sel_o.tier  = TIER_H;
      sel_o.upper = 1'b1;
    end
  end
endmodule

// File: rtl/stateen_access_check.sv
module stateen_access_check
  import stateen_pkg::*;
(
  input  tier_e                   tier_i,
  input  logic [IDX_W-1:0]        idx_i,
  input  logic                    ext_en_i,
  input  logic [1:0]              priv_i,
  input  logic                    virt_i,
  input  logic [STATEEN_REGS-1:0] m_open_i,
  input  logic [STATEEN_REGS-1:0] h_open_i,
  output logic                    virt_eff_o,
  output logic                    illegal_o,
  output logic                    virtual_o
);
  logic priv_ok;
  logic hit;

  assign hit        = (tier_i != TIER_NONE);
  assign virt_eff_o = virt_i && (priv_i != PRIV_M);

  always_comb begin
    unique case (tier_i)
      TIER_M:  priv_ok = (priv_i == PRIV_M);
      TIER_H:  priv_ok = (priv_i == PRIV_M) || ((priv_i == PRIV_S) && !virt_eff_o);
      TIER_S:  priv_ok = (priv_i == PRIV_M) || (priv_i == PRIV_S);
      default: priv_ok = 1'b0;
    endcase
  end

  // Higher-tier open bit gates the hypervisor and supervisor tiers.
  assign illegal_o = hit && (!ext_en_i || !priv_ok ||
                     ((tier_i != TIER_M) && !m_open_i[idx_i]));
  assign virtual_o = hit && !illegal_o && (tier_i == TIER_S) &&
                     virt_eff_o && !h_open_i[idx_i];
endmodule

// File: rtl/stateen_bank.sv
module stateen_bank
  import stateen_pkg::*;
#(
  parameter int unsigned          XLEN    = 32,
  parameter logic [STATEEN_W-1:0] WR_MASK = 64'h8000_0000_0000_0000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  sel_t            sel_i,
  input  logic            virt_eff_i,
  input  logic            commit_i,
  input  logic [XLEN-1:0] wdata_i,
  output logic [XLEN-1:0] rdata_o,
  output bank_t           m_q,
  output bank_t           h_q,
  output bank_t           s_q
);
  bank_t m_d, h_d, s_d;
  logic [STATEEN_W-1:0] cur, vis, mask, gate_s, wfull, upd;
  logic wr_en;

  always_comb begin
    gate_s = m_q[sel_i.idx] & (virt_eff_i ? h_q[sel_i.idx] : '1);
    cur    = '0;
    vis    = '0;
    mask   = '0;
    unique case (sel_i.tier)
      TIER_M: begin
        cur  = m_q[sel_i.idx];
        vis  = cur;
        mask = WR_MASK;
      end
      TIER_H: begin
        cur  = h_q[sel_i.idx];
        vis  = cur & m_q[sel_i.idx];
        mask = WR_MASK & m_q[sel_i.idx];
      end
      TIER_S: begin
        cur  = s_q[sel_i.idx];
        vis  = cur & gate_s;
        mask = WR_MASK & gate_s;
      end
      default: ;
    endcase
  end

  generate
    if (XLEN == 32) begin : g_half
      assign wfull   = sel_i.upper ? {wdata_i, cur[HALF_W-1:0]}
                                   : {cur[STATEEN_W-1:HALF_W], wdata_i};
      assign rdata_o = sel_i.upper ? vis[STATEEN_W-1:HALF_W] : vis[HALF_W-1:0];
    end else begin : g_full
      assign wfull   = STATEEN_W'(wdata_i);
      assign rdata_o = vis[XLEN-1:0];
    end
  endgenerate

  assign upd   = (cur & ~mask) | (wfull & mask);
  assign wr_en = commit_i;

  always_comb begin
    m_d = m_q;
    h_d = h_q;
    s_d = s_q;
    unique case (sel_i.tier)
      TIER_M:  m_d[sel_i.idx] = upd;
      TIER_H:  h_d[sel_i.idx] = upd;
      TIER_S:  s_d[sel_i.idx] = upd;
      default: ;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      m_q <= '0;
      h_q <= '0;
      s_q <= '0;
    end else if (wr_en) begin
      m_q <= m_d;
      h_q <= h_d;
      s_q <= s_d;
    end
  end
endmodule

// File: rtl/stateen_csr_file.sv
module stateen_csr_file
  import stateen_pkg::*;
#(
  parameter int unsigned          XLEN    = 32,
  parameter logic [STATEEN_W-1:0] WR_MASK = 64'h8000_0000_0000_0000
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            ext_en_i,
  input  logic [1:0]      priv_i,
  input  logic            virt_i,
  input  logic            req_valid_i,
  input  logic            req_we_i,
  input  logic [11:0]     req_addr_i,
  input  logic [XLEN-1:0] req_wdata_i,
  output logic            rsp_hit_o,
  output logic [XLEN-1:0] rsp_rdata_o,
  output logic            rsp_illegal_o,
  output logic            rsp_virtual_o
);
  sel_t                    sel;
  logic                    virt_eff, illegal, virtual_f, access_ok;
  logic [XLEN-1:0]         rdata_raw;
  logic [STATEEN_REGS-1:0] m_open, h_open;
  bank_t                   bank_m, bank_h, bank_s;

  stateen_addr_decode #(.XLEN(XLEN)) u_decode (
    .addr_i (req_addr_i),
    .sel_o  (sel)
  );

  generate
    for (genvar i = 0; i < STATEEN_REGS; i++) begin : g_open
      assign m_open[i] = bank_m[i][OPEN_BIT];
      assign h_open[i] = bank_h[i][OPEN_BIT];
    end
  endgenerate

  stateen_access_check u_check (
    .tier_i     (sel.tier),
    .idx_i      (sel.idx),
    .ext_en_i   (ext_en_i),
    .priv_i     (priv_i),
    .virt_i     (virt_i),
    .m_open_i   (m_open),
    .h_open_i   (h_open),
    .virt_eff_o (virt_eff),
    .illegal_o  (illegal),
    .virtual_o  (virtual_f)
  );

  assign access_ok = req_valid_i && (sel.tier != TIER_NONE) && !illegal && !virtual_f;

  stateen_bank #(.XLEN(XLEN), .WR_MASK(WR_MASK)) u_bank (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (sel),
    .virt_eff_i (virt_eff),
    .commit_i   (access_ok && req_we_i),
    .wdata_i    (req_wdata_i),
    .rdata_o    (rdata_raw),
    .m_q        (bank_m),
    .h_q        (bank_h),
    .s_q        (bank_s)
  );

  assign rsp_hit_o     = req_valid_i && (sel.tier != TIER_NONE);
  assign rsp_illegal_o = req_valid_i && illegal;
  assign rsp_virtual_o = req_valid_i && virtual_f;
  assign rsp_rdata_o   = access_ok ? rdata_raw : '0;
endmodule

// File: rtl/stateen_csr_file_sva.sv
module stateen_csr_file_sva
  import stateen_pkg::*;
#(
  parameter int unsigned          XLEN    = 32,
  parameter logic [STATEEN_W-1:0] WR_MASK = 64'h8000_0000_0000_0000
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ext_en_i,
  input logic             req_valid_i,
  input logic             req_we_i,
  input logic             is_htier,
  input logic [IDX_W-1:0] idx,
  input logic             rsp_hit_o,
  input logic [XLEN-1:0]  rsp_rdata_o,
  input logic             rsp_illegal_o,
  input logic             rsp_virtual_o,
  input bank_t            bank_m,
  input bank_t            bank_h,
  input bank_t            bank_s
);
  assert_fault_exclusive_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rsp_illegal_o && rsp_virtual_o));

  assert_virtual_cause_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_virtual_o |-> (bank_m[idx][OPEN_BIT] && !bank_h[idx][OPEN_BIT]));

  assert_htier_gated_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_hit_o && is_htier && !rsp_illegal_o) |-> bank_m[idx][OPEN_BIT]);

  assert_ext_off_faults_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_hit_o && !ext_en_i) |-> rsp_illegal_o);

  assert_fault_zero_data_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_illegal_o || rsp_virtual_o) |-> (rsp_rdata_o == '0));

  assert_fault_no_commit_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_we_i && (rsp_illegal_o || rsp_virtual_o)) |=>
      ($stable(bank_m) && $stable(bank_h) && $stable(bank_s)));

  assert_idle_no_change_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(req_valid_i && req_we_i) |=>
      ($stable(bank_m) && $stable(bank_h) && $stable(bank_s)));

  generate
    for (genvar i = 0; i < STATEEN_REGS; i++) begin : g_fixed
      assert_fixed_bits_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((bank_m[i] | bank_h[i] | bank_s[i]) & ~WR_MASK) == '0);
    end
  endgenerate
endmodule

bind stateen_csr_file stateen_csr_file_sva #(.XLEN(XLEN), .WR_MASK(WR_MASK)) u_sva (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .ext_en_i      (ext_en_i),
  .req_valid_i   (req_valid_i),
  .req_we_i      (req_we_i),
  .is_htier      (req_addr_i[11:8] == 4'h6),
  .idx           (req_addr_i[1:0]),
  .rsp_hit_o     (rsp_hit_o),
  .rsp_rdata_o   (rsp_rdata_o),
  .rsp_illegal_o (rsp_illegal_o),
  .rsp_virtual_o (rsp_virtual_o),
  .bank_m        (bank_m),
  .bank_h        (bank_h),
  .bank_s        (bank_s)
);

// File: tb/stateen_csr_file_bench.sv
`timescale 1ns/1ps
module stateen_csr_file_bench;
  localparam int WD_CYCLES = 200000;
  localparam logic [1:0] PM = 2'b11, PS = 2'b01, PU = 2'b00;

  logic        clk, rst_n, ext_en, virt, req_valid, req_we;
  logic [1:0]  priv;
  logic [11:0] req_addr;
  logic [31:0] req_wdata, rsp_rdata;
  logic        rsp_hit, rsp_illegal, rsp_virtual;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  typedef struct {
    logic        hit;
    logic        ill;
    logic        vf;
    logic [31:0] rd;
    string       tag;
  } exp_t;
  exp_t sb[$];

  stateen_csr_file #(.XLEN(32), .WR_MASK(64'h8000_0000_0000_00FF)) u_stateen_csr_file (
    .clk_i(clk), .rst_ni(rst_n), .ext_en_i(ext_en), .priv_i(priv), .virt_i(virt),
    .req_valid_i(req_valid), .req_we_i(req_we), .req_addr_i(req_addr),
    .req_wdata_i(req_wdata), .rsp_hit_o(rsp_hit), .rsp_rdata_o(rsp_rdata),
    .rsp_illegal_o(rsp_illegal), .rsp_virtual_o(rsp_virtual)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  task automatic op(input string tag, input logic en, input logic [1:0] pr,
                    input logic vt, input logic [11:0] a, input logic we,
                    input logic [31:0] wd, input logic eh, input logic ei,
                    input logic ev, input logic [31:0] er);
    exp_t e;
    @(negedge clk);
    ext_en = en; priv = pr; virt = vt; req_addr = a;
    req_we = we; req_wdata = wd; req_valid = 1'b1;
    e.hit = eh; e.ill = ei; e.vf = ev; e.rd = er; e.tag = tag;
    sb.push_back(e);
  endtask

  // Monitor: compare one response per valid cycle, away from the clock edge.
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (req_valid) begin
        n_tests++;
        if (sb.size() == 0) begin
          n_fail++;
          $display("FAIL monitor: response with no expected item, got rd=%h", rsp_rdata);
        end else begin
          exp_t e;
          e = sb.pop_front();
          if (rsp_hit !== e.hit || rsp_illegal !== e.ill ||
              rsp_virtual !== e.vf || rsp_rdata !== e.rd) begin
            n_fail++;
            $display("FAIL %s: got hit=%0b ill=%0b vf=%0b rd=%h, expected hit=%0b ill=%0b vf=%0b rd=%h",
                     e.tag, rsp_hit, rsp_illegal, rsp_virtual, rsp_rdata,
                     e.hit, e.ill, e.vf, e.rd);
          end
        end
      end
    end
  end

  initial begin
    #(WD_CYCLES * 4);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: run did not finish, got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; ext_en = 1'b1; priv = PM; virt = 1'b0;
    req_valid = 1'b0; req_we = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    op("R1 reset low half",        1, PM, 0, 12'h30C, 0, 0,            1, 0, 0, 32'h0);
    op("R1 reset upper half",      1, PM, 0, 12'h31C, 0, 0,            1, 0, 0, 32'h0);
    op("R6 htier closed",          1, PM, 0, 12'h61C, 0, 0,            1, 1, 0, 32'h0);
    op("R3 write low all ones",    1, PM, 0, 12'h30C, 1, 32'hFFFFFFFF, 1, 0, 0, 32'h0);
    op("R3 low keeps fixed bits",  1, PM, 0, 12'h30C, 0, 0,            1, 0, 0, 32'h000000FF);
    op("R10 upper untouched",      1, PM, 0, 12'h31C, 0, 0,            1, 0, 0, 32'h0);
    op("R10 write upper",          1, PM, 0, 12'h31C, 1, 32'hFFFFFFFF, 1, 0, 0, 32'h0);
    op("R10 upper only bit 63",    1, PM, 0, 12'h31C, 0, 0,            1, 0, 0, 32'h80000000);
    op("R10 low kept",             1, PM, 0, 12'h30C, 0, 0,            1, 0, 0, 32'h000000FF);
    op("R9 htier write",           1, PS, 0, 12'h60C, 1, 32'h000000A5, 1, 0, 0, 32'h0);
    op("R8 htier read",            1, PS, 0, 12'h60C, 0, 0,            1, 0, 0, 32'h000000A5);
    op("R3 narrow mtier",          1, PM, 0, 12'h30C, 1, 32'h0000000F, 1, 0, 0, 32'h000000FF);
    op("R8 htier masked read",     1, PS, 0, 12'h60C, 0, 0,            1, 0, 0, 32'h00000005);
    op("R9 htier masked write",    1, PS, 0, 12'h60C, 1, 32'h000000FF, 1, 0, 0, 32'h00000005);
    op("R9 htier after write",     1, PS, 0, 12'h60C, 0, 0,            1, 0, 0, 32'h0000000F);
    op("R3 widen mtier",           1, PM, 0, 12'h30C, 1, 32'h000000FF, 1, 0, 0, 32'h0000000F);
    op("R9 htier held bits",       1, PS, 0, 12'h60C, 0, 0,            1, 0, 0, 32'h000000AF);
    op("R9 stier write",           1, PS, 0, 12'h10C, 1, 32'h0000003C, 1, 0, 0, 32'h0);
    op("R8 stier read",            1, PS, 0, 12'h10C, 0, 0,            1, 0, 0, 32'h0000003C);
    op("R7 virtual fault",         1, PS, 1, 12'h10C, 0, 0,            1, 0, 1, 32'h0);
    op("R10 htier open bit",       1, PS, 0, 12'h61C, 1, 32'h80000000, 1, 0, 0, 32'h0);
    op("R8 stier virt read",       1, PS, 1, 12'h10C, 0, 0,            1, 0, 0, 32'h0000002C);
    op("R9 stier virt write",      1, PS, 1, 12'h10C, 1, 32'h000000FF, 1, 0, 0, 32'h0000002C);
    op("R9 stier virt readback",   1, PS, 1, 12'h10C, 0, 0,            1, 0, 0, 32'h000000AF);
    op("R9 stier raw readback",    1, PS, 0, 12'h10C, 0, 0,            1, 0, 0, 32'h000000BF);
    op("R7 stier mtier closed",    1, PS, 0, 12'h10D, 0, 0,            1, 1, 0, 32'h0);
    op("R5 htier from virt",       1, PS, 1, 12'h61C, 1, 32'h0,        1, 1, 0, 32'h0);
    op("R11 htier not written",    1, PS, 0, 12'h61C, 0, 0,            1, 0, 0, 32'h80000000);
    op("R5 stier from user",       1, PU, 0, 12'h10C, 1, 32'h0,        1, 1, 0, 32'h0);
    op("R11 stier not written",    1, PS, 0, 12'h10C, 0, 0,            1, 0, 0, 32'h000000BF);
    op("R2 no stier upper alias",  1, PM, 0, 12'h11C, 0, 0,            0, 0, 0, 32'h0);
    op("R2 below range",           1, PM, 0, 12'h30B, 0, 0,            0, 0, 0, 32'h0);
    op("R2 last mtier alias",      1, PM, 0, 12'h31F, 0, 0,            1, 0, 0, 32'h0);
    op("R2 last stier closed",     1, PS, 0, 12'h10F, 0, 0,            1, 1, 0, 32'h0);
    op("R5 mtier from super",      1, PS, 0, 12'h30C, 0, 0,            1, 1, 0, 32'h0);
    op("R5 htier from user",       1, PU, 0, 12'h60C, 0, 0,            1, 1, 0, 32'h0);
    op("R5 virt ignored in M",     1, PM, 1, 12'h60C, 0, 0,            1, 0, 0, 32'h000000AF);
    op("R4 ext off read",          0, PM, 0, 12'h30C, 0, 0,            1, 1, 0, 32'h0);
    op("R4 ext off write",         0, PM, 0, 12'h31C, 1, 32'h0,        1, 1, 0, 32'h0);
    op("R11 ext off no commit",    1, PM, 0, 12'h31C, 0, 0,            1, 0, 0, 32'h80000000);

    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    if (sb.size() != 0) begin
      n_fail++;
      $display("FAIL scoreboard: got %0d pending items, expected 0", sb.size());
    end
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule